// File: doc/BRIEF.md
# Next-PC and Control-Transfer Unit

This block owns the 32-bit program counter of a simple in-order core and works out the address of the next instruction each time one instruction retires. The caller presents the instruction word, the two register operands it names, the return, exception-return and break-return addresses, and the saved status word. It then pulses a one-cycle advance strobe. On that clock edge the PC moves to its next value. For one cycle afterwards the block reports any register write-back (index and value), any request to restore status, or an illegal-instruction flag.

Its scope is the control-transfer subset of the instruction set:
- the absolute jump and call, which splice a word index under the top PC nibble;
- the PC-relative unconditional branch;
- six conditional branches, with signed and unsigned compares;
- register-indirect jump, call and the three return forms;
- reading the PC into a register.

Every other encoding is flagged as illegal and leaves the PC where it was.

The control is a three-state machine:
- ST_READY: idle, no side effect shown.
- ST_RETIRED: the write-back and status-restore results of the last advance are visible.
- ST_FAULT: the illegal flag is shown.

Transitions, taken from any state:
- go_fault: advance with an illegal encoding.
- go_retire: advance with a legal encoding.
- go_idle: no advance.

Top module: `npc_unit`

## Requirements
- R1: Reset loads the PC with the parameter RESET_VEC and holds rd_we_o, status_we_o and illegal_o low.
- R2: The PC changes only on a clock edge where advance_i is high. Write-back, status-restore and illegal outputs appear in the cycle right after that edge and last exactly one cycle.
- R3: Major opcode (bits [5:0]) 0x01 sets the PC to {PC[31:28], instr[31:6], 2'b00}.
- R4: Major opcode 0x00 jumps as in R3 and writes PC+4 to register 31.
- R5: Major opcode 0x06 sets the PC to PC + 4 + the sign-extended 16-bit immediate in bits [21:6], with the immediate's two low bits cleared.
- R6: Opcode 0x0E (taken when rA >= rB, signed) and opcode 0x16 (taken when rA < rB, signed) branch to the R5 target. rA is the register in bits [31:27] and rB the register in bits [26:22]; their values arrive on reg_a_i and reg_b_i.
- R7: Opcode 0x1E branches when rA != rB, and opcode 0x26 branches when rA == rB.
- R8: Opcode 0x2E (taken when rA >= rB, unsigned) and opcode 0x36 (taken when rA < rB, unsigned) branch to the R5 target.
- R9: A conditional branch that is not taken sets the PC to PC+4 and requests no write.
- R10: With major opcode 0x3A and secondary code in bits [16:11], code 0x05 loads the PC from ra_i, 0x09 from ba_i, and 0x0D from reg_a_i.
- R11: Secondary code 0x1D loads the PC from reg_a_i and writes the old PC+4 to register 31.
- R12: Secondary code 0x01 loads the PC from ea_i and raises status_we_o with status_data_o equal to estatus_i.
- R13: Secondary code 0x1C writes PC+4 to the register in bits [21:17] and advances the PC to PC+4. When that register is 0, no write is requested.
- R14: Any other major opcode, or any other secondary code, raises illegal_o for one cycle, leaves the PC unchanged and requests no write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| advance_i | input | 1 | Retire the presented instruction on this edge |
| instr_i | input | 32 | Instruction word |
| reg_a_i | input | 32 | Value of register A |
| reg_b_i | input | 32 | Value of register B |
| ra_i | input | 32 | Return-address register value |
| ea_i | input | 32 | Exception-return address |
| ba_i | input | 32 | Break-return address |
| estatus_i | input | 32 | Saved status word |
| pc_o | output | 32 | Current program counter |
| rd_we_o | output | 1 | Register write-back request |
| rd_idx_o | output | 5 | Write-back register index |
| rd_data_o | output | 32 | Write-back value |
| status_we_o | output | 1 | Status-restore request |
| status_data_o | output | 32 | Value to restore into status |
| illegal_o | output | 1 | Illegal-instruction flag |

## Verification
The PC register sits behind one edge, so a wrong target or a wrong taken decision shows on pc_o in the cycle right after the strobe. It also moves the base for every later instruction, so one error spreads through the rest of the sequence. A state machine stuck in ST_RETIRED or ST_FAULT shows up one cycle later as a write-back, restore or illegal pulse that does not drop. A stale write-back index or value shows up in that same pulse cycle. The bench therefore checks each result in the pulse cycle and checks that it is quiet one cycle later.

// File: rtl/npc_pkg.sv
package npc_pkg;
    localparam int unsigned WORD_W = 32;
    localparam int unsigned REG_W  = 5;
    localparam int unsigned OP_W   = 6;

    localparam logic [OP_W-1:0] OP_CALL  = 6'h00;
    localparam logic [OP_W-1:0] OP_JUMP  = 6'h01;
    localparam logic [OP_W-1:0] OP_BR    = 6'h06;
    localparam logic [OP_W-1:0] OP_BGE   = 6'h0E;
    localparam logic [OP_W-1:0] OP_BLT   = 6'h16;
    localparam logic [OP_W-1:0] OP_BNE   = 6'h1E;
    localparam logic [OP_W-1:0] OP_BEQ   = 6'h26;
    localparam logic [OP_W-1:0] OP_BGEU  = 6'h2E;
    localparam logic [OP_W-1:0] OP_BLTU  = 6'h36;
    localparam logic [OP_W-1:0] OP_RFMT  = 6'h3A;

    localparam logic [OP_W-1:0] SX_ERET   = 6'h01;
    localparam logic [OP_W-1:0] SX_RET    = 6'h05;
    localparam logic [OP_W-1:0] SX_BRET   = 6'h09;
    localparam logic [OP_W-1:0] SX_JMPR   = 6'h0D;
    localparam logic [OP_W-1:0] SX_PCRD   = 6'h1C;
    localparam logic [OP_W-1:0] SX_CALLR  = 6'h1D;

    localparam logic [REG_W-1:0] LINK_REG = 5'd31;

    typedef enum logic [3:0] {
        K_ILLEGAL, K_JUMP, K_CALL, K_BR, K_BCOND,
        K_RET, K_BRET, K_JMPR, K_CALLR, K_ERET, K_PCRD
    } kind_e;

    typedef enum logic [2:0] {
        CMP_GE, CMP_LT, CMP_NE, CMP_EQ, CMP_GEU, CMP_LTU
    } cmp_e;

    typedef enum logic [1:0] {
        ST_READY, ST_RETIRED, ST_FAULT
    } state_e;

    typedef struct packed {
        kind_e             kind;
        cmp_e              cmp;
        logic [REG_W-1:0]  dst;
        logic [15:0]       imm16;
        logic [25:0]       imm26;
    } dec_t;
endpackage

// File: rtl/npc_decode.sv
module npc_decode
    import npc_pkg::*;
(
    input  logic [WORD_W-1:0] instr_i,
    output dec_t              dec_o
);
    logic [OP_W-1:0] major;
    logic [OP_W-1:0] minor;

    assign major = instr_i[5:0];
    assign minor = instr_i[16:11];

    always_comb begin
        dec_o.kind  = K_ILLEGAL;
        dec_o.cmp   = CMP_EQ;
        dec_o.dst   = instr_i[21:17];
        dec_o.imm16 = instr_i[21:6];
        dec_o.imm26 = instr_i[31:6];
        case (major)
            OP_CALL: dec_o.kind = K_CALL;
            OP_JUMP: dec_o.kind = K_JUMP;
            OP_BR:   dec_o.kind = K_BR;
            OP_BGE:  begin dec_o.kind = K_BCOND; dec_o.cmp = CMP_GE;  end
            OP_BLT:  begin dec_o.kind = K_BCOND; dec_o.cmp = CMP_LT;  end
            OP_BNE:  begin dec_o.kind = K_BCOND; dec_o.cmp = CMP_NE;  end
            OP_BEQ:  begin dec_o.kind = K_BCOND; dec_o.cmp = CMP_EQ;  end
            OP_BGEU: begin dec_o.kind = K_BCOND; dec_o.cmp = CMP_GEU; end
            OP_BLTU: begin dec_o.kind = K_BCOND; dec_o.cmp = CMP_LTU; end
            OP_RFMT: begin
                case (minor)
                    SX_ERET:  dec_o.kind = K_ERET;
                    SX_RET:   dec_o.kind = K_RET;
                    SX_BRET:  dec_o.kind = K_BRET;
                    SX_JMPR:  dec_o.kind = K_JMPR;
                    SX_PCRD:  dec_o.kind = K_PCRD;
                    SX_CALLR: dec_o.kind = K_CALLR;
                    default:  dec_o.kind = K_ILLEGAL;
                endcase
            end
            default: dec_o.kind = K_ILLEGAL;
        endcase
    end
endmodule

// File: rtl/npc_compare.sv
module npc_compare
    import npc_pkg::*;
#(
    parameter int unsigned W = WORD_W
) (
    input  logic [W-1:0] a_i,
    input  logic [W-1:0] b_i,
    input  cmp_e         sel_i,
    output logic         taken_o
);
    logic lt_s;
    logic lt_u;
    logic eq;

    assign lt_s = $signed(a_i) < $signed(b_i);
    assign lt_u = a_i < b_i;
    assign eq   = a_i == b_i;

    always_comb begin
        case (sel_i)
            CMP_GE:  taken_o = !lt_s;
            CMP_LT:  taken_o = lt_s;
            CMP_NE:  taken_o = !eq;
            CMP_EQ:  taken_o = eq;
            CMP_GEU: taken_o = !lt_u;
            CMP_LTU: taken_o = lt_u;
            default: taken_o = 1'b0;
        endcase
    end
endmodule

// File: rtl/npc_target.sv
module npc_target
    import npc_pkg::*;
#(
    parameter int unsigned W = WORD_W
) (
    input  logic [W-1:0]     pc_i,
    input  dec_t             dec_i,
    input  logic             taken_i,
    input  logic [W-1:0]     reg_a_i,
    input  logic [W-1:0]     ra_i,
    input  logic [W-1:0]     ea_i,
    input  logic [W-1:0]     ba_i,
    output logic [W-1:0]     next_pc_o,
    output logic             wb_en_o,
    output logic [REG_W-1:0] wb_idx_o,
    output logic [W-1:0]     wb_data_o,
    output logic             st_en_o,
    output logic             illegal_o
);
    localparam int unsigned SEXT_W = W - 16;

    logic [W-1:0] seq_pc;
    logic [W-1:0] rel_pc;
    logic [W-1:0] abs_pc;

    assign seq_pc    = pc_i + W'(4);
    assign rel_pc    = seq_pc + {{SEXT_W{dec_i.imm16[15]}}, dec_i.imm16[15:2], 2'b00};
    assign abs_pc    = {pc_i[W-1:W-4], dec_i.imm26, 2'b00};
    assign wb_data_o = seq_pc;

    always_comb begin
        next_pc_o = seq_pc;
        wb_en_o   = 1'b0;
        wb_idx_o  = LINK_REG;
        st_en_o   = 1'b0;
        illegal_o = 1'b0;
        case (dec_i.kind)
            K_JUMP:  next_pc_o = abs_pc;
            K_CALL:  begin next_pc_o = abs_pc; wb_en_o = 1'b1; end
            K_BR:    next_pc_o = rel_pc;
            K_BCOND: next_pc_o = taken_i ? rel_pc : seq_pc;
            K_RET:   next_pc_o = ra_i;
            K_BRET:  next_pc_o = ba_i;
            K_JMPR:  next_pc_o = reg_a_i;
            K_CALLR: begin next_pc_o = reg_a_i; wb_en_o = 1'b1; end
            K_ERET:  begin next_pc_o = ea_i; st_en_o = 1'b1; end
            K_PCRD:  begin
                wb_idx_o = dec_i.dst;
                wb_en_o  = dec_i.dst != '0;
            end
            default: begin
                next_pc_o = pc_i;
                illegal_o = 1'b1;
            end
        endcase
    end
endmodule

// File: rtl/npc_unit.sv
module npc_unit
    import npc_pkg::*;
#(
    parameter logic [31:0] RESET_VEC = 32'hA000_0100
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  advance_i,
    input  logic [31:0]           instr_i,
    input  logic [31:0]           reg_a_i,
    input  logic [31:0]           reg_b_i,
    input  logic [31:0]           ra_i,
    input  logic [31:0]           ea_i,
    input  logic [31:0]           ba_i,
    input  logic [31:0]           estatus_i,
    output logic [31:0]           pc_o,
    output logic                  rd_we_o,
    output logic [4:0]            rd_idx_o,
    output logic [31:0]           rd_data_o,
    output logic                  status_we_o,
    output logic [31:0]           status_data_o,
    output logic                  illegal_o
);
    dec_t               dec;
    logic               taken;
    logic [WORD_W-1:0]  nxt_pc;
    logic               nxt_wb_en;
    logic [REG_W-1:0]   nxt_wb_idx;
    logic [WORD_W-1:0]  nxt_wb_data;
    logic               nxt_st_en;
    logic               nxt_illegal;

    state_e             state_q;
    state_e             state_d;
    logic [WORD_W-1:0]  pc_q;
    logic               wb_en_q;
    logic [REG_W-1:0]   wb_idx_q;
    logic [WORD_W-1:0]  wb_data_q;
    logic               st_en_q;
    logic [WORD_W-1:0]  st_data_q;

    npc_decode u_decode (
        .instr_i (instr_i),
        .dec_o   (dec)
    );

    npc_compare #(.W(WORD_W)) u_compare (
        .a_i     (reg_a_i),
        .b_i     (reg_b_i),
        .sel_i   (dec.cmp),
        .taken_o (taken)
    );

    npc_target #(.W(WORD_W)) u_target (
        .pc_i      (pc_q),
        .dec_i     (dec),
        .taken_i   (taken),
        .reg_a_i   (reg_a_i),
        .ra_i      (ra_i),
        .ea_i      (ea_i),
        .ba_i      (ba_i),
        .next_pc_o (nxt_pc),
        .wb_en_o   (nxt_wb_en),
        .wb_idx_o  (nxt_wb_idx),
        .wb_data_o (nxt_wb_data),
        .st_en_o   (nxt_st_en),
        .illegal_o (nxt_illegal)
    );

    // next-state logic: go_fault, go_retire, go_idle
    always_comb begin
        state_d = ST_READY;
        unique case (state_q)
            ST_READY, ST_RETIRED, ST_FAULT: begin
                if (advance_i && nxt_illegal)
                    state_d = ST_FAULT;
                else if (advance_i)
                    state_d = ST_RETIRED;
                else
                    state_d = ST_READY;
            end
            default: state_d = ST_READY;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n)
            state_q <= ST_READY;
        else
            state_q <= state_d;
    end

    // PC and retire payload
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pc_q      <= RESET_VEC;
            wb_en_q   <= 1'b0;
            wb_idx_q  <= '0;
            wb_data_q <= '0;
            st_en_q   <= 1'b0;
            st_data_q <= '0;
        end else if (advance_i) begin
            pc_q      <= nxt_pc;
            wb_en_q   <= nxt_wb_en;
            wb_idx_q  <= nxt_wb_idx;
            wb_data_q <= nxt_wb_data;
            st_en_q   <= nxt_st_en;
            st_data_q <= estatus_i;
        end
    end

    // outputs from state
    always_comb begin
        pc_o          = pc_q;
        rd_idx_o      = wb_idx_q;
        rd_data_o     = wb_data_q;
        status_data_o = st_data_q;
        rd_we_o       = 1'b0;
        status_we_o   = 1'b0;
        illegal_o     = 1'b0;
        unique case (state_q)
            ST_READY: ;
            ST_RETIRED: begin
                rd_we_o     = wb_en_q;
                status_we_o = st_en_q;
            end
            ST_FAULT: illegal_o = 1'b1;
            default: ;
        endcase
    end
endmodule

// File: rtl/npc_unit_chk.sv
module npc_unit_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        advance_i,
    input logic [31:0] ea_i,
    input logic [31:0] estatus_i,
    input logic [31:0] pc_o,
    input logic        rd_we_o,
    input logic [4:0]  rd_idx_o,
    input logic [31:0] rd_data_o,
    input logic        status_we_o,
    input logic [31:0] status_data_o,
    input logic        illegal_o
);
    // R2
    pc_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !advance_i |=> $stable(pc_o));

    // R2
    pulse_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !advance_i |=> !rd_we_o && !status_we_o && !illegal_o);

    // R14
    illegal_pc_chk: assert property (@(posedge clk) disable iff (!rst_n)
        illegal_o |-> $stable(pc_o) && !rd_we_o && !status_we_o);

    // R12
    eret_chk: assert property (@(posedge clk) disable iff (!rst_n)
        status_we_o |-> pc_o == $past(ea_i) && status_data_o == $past(estatus_i));

    // R13
    wb_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_we_o |-> rd_idx_o != 5'd0);

    // R4
    wb_link_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_we_o |-> rd_data_o == $past(pc_o) + 32'd4);
endmodule

bind npc_unit npc_unit_chk u_npc_unit_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .advance_i     (advance_i),
    .ea_i          (ea_i),
    .estatus_i     (estatus_i),
    .pc_o          (pc_o),
    .rd_we_o       (rd_we_o),
    .rd_idx_o      (rd_idx_o),
    .rd_data_o     (rd_data_o),
    .status_we_o   (status_we_o),
    .status_data_o (status_data_o),
    .illegal_o     (illegal_o)
);

// File: tb/test_npc_unit.sv
module test_npc_unit;
    localparam logic [31:0] RST_PC = 32'hA000_0100;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        advance_i = 1'b0;
    logic [31:0] instr_i = '0;
    logic [31:0] reg_a_i = '0;
    logic [31:0] reg_b_i = '0;
    logic [31:0] ra_i = 32'h1111_2220;
    logic [31:0] ea_i = 32'h3333_4440;
    logic [31:0] ba_i = 32'h5555_6660;
    logic [31:0] estatus_i = 32'h0000_0005;
    logic [31:0] pc_o;
    logic        rd_we_o;
    logic [4:0]  rd_idx_o;
    logic [31:0] rd_data_o;
    logic        status_we_o;
    logic [31:0] status_data_o;
    logic        illegal_o;

    int n_vec = 0;
    int n_bad = 0;
    logic done = 1'b0;
    logic [31:0] epc;

    always #2 clk = ~clk;

    npc_unit #(.RESET_VEC(RST_PC)) i_npc_unit (
        .clk(clk), .rst_n(rst_n), .advance_i(advance_i), .instr_i(instr_i),
        .reg_a_i(reg_a_i), .reg_b_i(reg_b_i), .ra_i(ra_i), .ea_i(ea_i),
        .ba_i(ba_i), .estatus_i(estatus_i), .pc_o(pc_o), .rd_we_o(rd_we_o),
        .rd_idx_o(rd_idx_o), .rd_data_o(rd_data_o), .status_we_o(status_we_o),
        .status_data_o(status_data_o), .illegal_o(illegal_o)
    );

    function automatic logic [31:0] enc_i(input logic [5:0] op, input logic [15:0] imm);
        return {5'd1, 5'd2, imm, op};
    endfunction
    function automatic logic [31:0] enc_j(input logic [5:0] op, input logic [25:0] imm);
        return {imm, op};
    endfunction
    function automatic logic [31:0] enc_r(input logic [5:0] opx, input logic [4:0] c);
        return {5'd1, 5'd2, c, opx, 5'd0, 6'h3A};
    endfunction
    function automatic logic [31:0] rel(input logic [31:0] pc, input logic [15:0] imm);
        return pc + 32'd4 + {{16{imm[15]}}, imm[15:2], 2'b00};
    endfunction

    task automatic chk(input string req, input string what, input logic [31:0] got, input logic [31:0] exp);
        n_vec++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %h expected %h", req, what, got, exp);
        end
    endtask

    task automatic apply(input logic [31:0] ins, input logic [31:0] a, input logic [31:0] b);
        @(negedge clk);
        instr_i = ins; reg_a_i = a; reg_b_i = b; advance_i = 1'b1;
        @(negedge clk);
        advance_i = 1'b0;
    endtask

    task automatic expect_out(input string req, input logic [31:0] pc, input logic we,
                              input logic [4:0] idx, input logic st, input logic ill);
        chk(req, "pc", pc_o, pc);
        chk(req, "rd_we", {31'd0, rd_we_o}, {31'd0, we});
        if (we) begin
            chk(req, "rd_idx", {27'd0, rd_idx_o}, {27'd0, idx});
            chk(req, "rd_data", rd_data_o, epc + 32'd4);
        end
        chk(req, "status_we", {31'd0, status_we_o}, {31'd0, st});
        chk(req, "illegal", {31'd0, illegal_o}, {31'd0, ill});
        epc = pc;
    endtask

    task automatic t_reset;
        chk("R1", "pc", pc_o, RST_PC);
        chk("R1", "pulses", {29'd0, rd_we_o, status_we_o, illegal_o}, 32'd0);
        epc = RST_PC;
    endtask

    task automatic t_jump;
        logic [31:0] tgt;
        tgt = {epc[31:28], 26'h1234567, 2'b00};
        apply(enc_j(6'h01, 26'h1234567), '0, '0);
        expect_out("R3", tgt, 1'b0, 5'd0, 1'b0, 1'b0);
        repeat (3) @(negedge clk);
        chk("R2", "pc held", pc_o, tgt);
    endtask

    task automatic t_call;
        logic [31:0] tgt;
        tgt = {epc[31:28], 26'h0000040, 2'b00};
        apply(enc_j(6'h00, 26'h0000040), '0, '0);
        expect_out("R4", tgt, 1'b1, 5'd31, 1'b0, 1'b0);
        @(negedge clk);
        chk("R2", "rd_we one cycle", {31'd0, rd_we_o}, 32'd0);
    endtask

    task automatic t_br;
        apply(enc_i(6'h06, 16'hFFF3), '0, '0);
        expect_out("R5", rel(epc, 16'hFFF3), 1'b0, 5'd0, 1'b0, 1'b0);
        apply(enc_i(6'h06, 16'h0107), '0, '0);
        expect_out("R5", rel(epc, 16'h0107), 1'b0, 5'd0, 1'b0, 1'b0);
    endtask

    task automatic t_signed;
        apply(enc_i(6'h0E, 16'h0020), 32'hFFFF_FFFF, 32'd1);
        expect_out("R6 R9", epc + 32'd4, 1'b0, 5'd0, 1'b0, 1'b0);
        apply(enc_i(6'h0E, 16'h0020), 32'd7, 32'd7);
        expect_out("R6", rel(epc, 16'h0020), 1'b0, 5'd0, 1'b0, 1'b0);
        apply(enc_i(6'h16, 16'hFF00), 32'hFFFF_FFFF, 32'd1);
        expect_out("R6", rel(epc, 16'hFF00), 1'b0, 5'd0, 1'b0, 1'b0);
    endtask

    task automatic t_eqne;
        apply(enc_i(6'h26, 16'h0040), 32'd9, 32'd9);
        expect_out("R7", rel(epc, 16'h0040), 1'b0, 5'd0, 1'b0, 1'b0);
        apply(enc_i(6'h1E, 16'h0040), 32'd9, 32'd9);
        expect_out("R7 R9", epc + 32'd4, 1'b0, 5'd0, 1'b0, 1'b0);
        apply(enc_i(6'h1E, 16'h0044), 32'd9, 32'd8);
        expect_out("R7", rel(epc, 16'h0044), 1'b0, 5'd0, 1'b0, 1'b0);
    endtask

    task automatic t_unsigned;
        apply(enc_i(6'h2E, 16'h0010), 32'hFFFF_FFFF, 32'd1);
        expect_out("R8", rel(epc, 16'h0010), 1'b0, 5'd0, 1'b0, 1'b0);
        apply(enc_i(6'h36, 16'h0010), 32'hFFFF_FFFF, 32'd1);
        expect_out("R8 R9", epc + 32'd4, 1'b0, 5'd0, 1'b0, 1'b0);
    endtask

    task automatic t_regjump;
        apply(enc_r(6'h05, 5'd0), '0, '0);
        expect_out("R10", ra_i, 1'b0, 5'd0, 1'b0, 1'b0);
        apply(enc_r(6'h09, 5'd0), '0, '0);
        expect_out("R10", ba_i, 1'b0, 5'd0, 1'b0, 1'b0);
        apply(enc_r(6'h0D, 5'd0), 32'h0BAD_F00C, '0);
        expect_out("R10", 32'h0BAD_F00C, 1'b0, 5'd0, 1'b0, 1'b0);
    endtask

    task automatic t_callr;
        apply(enc_r(6'h1D, 5'd0), 32'h0000_8000, '0);
        expect_out("R11", 32'h0000_8000, 1'b1, 5'd31, 1'b0, 1'b0);
    endtask

    task automatic t_eret;
        apply(enc_r(6'h01, 5'd0), '0, '0);
        chk("R12", "status_data", status_data_o, estatus_i);
        expect_out("R12", ea_i, 1'b0, 5'd0, 1'b1, 1'b0);
        @(negedge clk);
        chk("R2", "status_we one cycle", {31'd0, status_we_o}, 32'd0);
    endtask

    task automatic t_nextpc;
        apply(enc_r(6'h1C, 5'd7), '0, '0);
        expect_out("R13", epc + 32'd4, 1'b1, 5'd7, 1'b0, 1'b0);
        apply(enc_r(6'h1C, 5'd0), '0, '0);
        expect_out("R13", epc + 32'd4, 1'b0, 5'd0, 1'b0, 1'b0);
    endtask

    task automatic t_illegal;
        apply(enc_i(6'h04, 16'h0100), '0, '0);
        expect_out("R14", epc, 1'b0, 5'd0, 1'b0, 1'b1);
        @(negedge clk);
        chk("R14", "flag one cycle", {31'd0, illegal_o}, 32'd0);
        apply(enc_r(6'h00, 5'd3), '0, '0);
        expect_out("R14", epc, 1'b0, 5'd0, 1'b0, 1'b1);
    endtask

    task automatic finish_run;
        if (!done) begin
            done = 1'b1;
            $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_vec++;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_jump();
        t_call();
        t_br();
        t_signed();
        t_eqne();
        t_unsigned();
        t_regjump();
        t_callr();
        t_eret();
        t_nextpc();
        t_illegal();
        repeat (2) @(negedge clk);
        finish_run();
    end
endmodule